// File: doc/BRIEF.md
# Sector bit-error corrector

This block repairs one 512-byte sector that sits in a local byte-wide buffer, using the results of an upstream error-locating decoder. When `start` is pulsed it captures a packed word of up to eight 13-bit bit-error positions and a 4-bit error count. Each position holds an index adjustment in its two low bits. The block undoes that adjustment and flips each addressed data bit. Each flip is a read followed by a write on the buffer port. A position that lands outside the 4096 data bits is skipped. A count code of 15 marks the sector as beyond repair: the buffer is left untouched and a flag is raised instead.

When the sequence finishes, the block pulses `done` for one cycle. It then holds two results until the next accepted start: the number of bits it actually changed and the uncorrectable flag. It does not compute syndromes, search for error positions, or move sector data anywhere. The buffer has one port with synchronous reads: read data is valid in the cycle after a read is requested.

Top module: `sector_bitfix`

## Requirements
- R1: After a synchronous active-low reset, `done`, `uncorrectable` and `fix_count` are 0, and neither `buf_rd_en` nor `buf_wr_en` is asserted until a start is accepted.
- R2: Position slot k is taken from bits 13k+12 down to 13k of `err_locs`. Slot 0 is in bits 12:0 and slot 7 is in bits 103:91.
- R3: Before use, bits 0 and 1 of every position are inverted. The result is the adjusted position.
- R4: For an in-range adjusted position p, the block reads byte p[11:3]. In the following cycle it writes the same byte back with only bit p[2:0] inverted. Two positions naming the same bit therefore restore it.
- R5: Slots are handled in index order from slot 0. With a count of 0 to 8, exactly that many slots are used. A count of 9 to 14 is treated as 8. Slots at or above the count are never applied.
- R6: A count of 15 modifies no byte and makes no buffer access. It raises `uncorrectable` with `fix_count` of 0 at `done`.
- R7: An adjusted position of 4096 or more makes no buffer access. It costs one cycle and does not count as a fix.
- R8: If start is accepted at edge e, `done` is high for exactly one cycle, following edge e+2a+b+1. Here a is the number of in-range slots used and b the number of out-of-range slots used. An in-range slot's read and write occupy two consecutive cycles.
- R9: `fix_count` equals the number of bits flipped. It and `uncorrectable` change only in the `done` cycle and hold otherwise.
- R10: A start that arrives while a sequence is in progress, up to and including the edge that raises `done`, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a correction pass (sampled when idle) |
| err_locs | input | 104 | Eight packed 13-bit error positions |
| err_count | input | 4 | Number of valid positions; 15 = uncorrectable |
| buf_addr | output | 9 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read request |
| buf_wr_en | output | 1 | Buffer write request |
| buf_wdata | output | 8 | Byte written back |
| buf_rdata | input | 8 | Byte read, valid the cycle after the request |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 4 | Bits flipped in the last pass |
| uncorrectable | output | 1 | Last pass had count code 15 |

## Verification
The bench builds the block with its default parameters: 13-bit fields, eight slots, a 512-byte sector and a 4-bit count. These values put the exact 4095/4096 range edge and the index adjustment of the two low bits within reach. They also cover the clamp for counts 9 to 14 and the reserved code 15. A behavioural model predicts the buffer access pattern and the `done` pulse for every cycle, keeps a copy of the sector image, and compares both against the design.

// File: rtl/sbf_pkg.sv
// Shared types and helpers for the sector bit-error corrector.
// Assumes byte-wide buffer data.
package sbf_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_FLIP = 2'd2
    } seq_state_e;

    // One-hot byte mask with a single bit set at position pos.
    function automatic logic [BYTE_W-1:0] bit_select(input logic [2:0] pos);
        logic [BYTE_W-1:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sbf_loc_unpack.sv
// Holds the captured position word, splits it into slots, undoes the
// two-bit index adjustment and range-checks the slot picked by idx.
// Assumes LOC_W >= ADDR_W + 3.
module sbf_loc_unpack #(
    parameter int LOC_W        = 13,
    parameter int MAX_LOCS     = 8,
    parameter int SECTOR_BYTES = 512,
    localparam int PACK_W      = LOC_W * MAX_LOCS,
    localparam int IDX_W       = $clog2(MAX_LOCS + 1),
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int BIT_LIMIT   = SECTOR_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PACK_W-1:0] locs_in,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_pos,
    output logic              in_range
);

    localparam logic [LOC_W:0]   LIMIT_V = (LOC_W + 1)'(BIT_LIMIT);
    localparam logic [LOC_W-1:0] ADJ_V   = LOC_W'(3);

    logic [PACK_W-1:0] locs_q;
    logic [LOC_W-1:0]  slot [MAX_LOCS];
    logic [LOC_W-1:0]  sel;

    // Capture the position word when a pass is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locs_q <= '0;
        else if (load)
            locs_q <= locs_in;
    end

    // Split the word into slots with the low two bits restored.
    for (genvar k = 0; k < MAX_LOCS; k++) begin : g_slot
        assign slot[k] = locs_q[k*LOC_W +: LOC_W] ^ ADJ_V;
    end

    // Pick the slot named by idx; past the last slot yields zero.
    always_comb begin
        sel = '0;
        for (int k = 0; k < MAX_LOCS; k++) begin
            if (idx == IDX_W'(k))
                sel = slot[k];
        end
    end

    assign in_range  = ({1'b0, sel} < LIMIT_V);
    assign byte_addr = sel[ADDR_W+2:3];
    assign bit_pos   = sel[2:0];

endmodule

// File: rtl/sbf_seq.sv
// Pass sequencer: accepts start when idle, walks slots in order, spends two
// cycles on each in-range slot and one on each out-of-range slot, and then
// pulses done and updates the held results.
// Assumes the slot selected by idx is range-checked combinationally.
module sbf_seq #(
    parameter int CNT_W    = 4,
    parameter int MAX_LOCS = 8,
    localparam int IDX_W   = $clog2(MAX_LOCS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  err_count,
    input  logic              in_range,
    output logic              load,
    output logic [IDX_W-1:0]  idx,
    output logic              rd_req,
    output logic              wr_req,
    output logic              done,
    output logic [IDX_W-1:0]  fix_count,
    output logic              uncorrectable
);
    import sbf_pkg::*;

    localparam logic [CNT_W-1:0] FULL_CODE = '1;
    localparam logic [CNT_W-1:0] CAP_CODE  = CNT_W'(MAX_LOCS);

    seq_state_e       state;
    logic [IDX_W-1:0] n_used;
    logic [IDX_W-1:0] n_next;
    logic [IDX_W-1:0] fixed;
    logic             unc_pend;
    logic             at_end;

    // Number of slots to use for the count offered at start.
    always_comb begin
        if (err_count == FULL_CODE)
            n_next = '0;
        else if (err_count > CAP_CODE)
            n_next = IDX_W'(MAX_LOCS);
        else
            n_next = IDX_W'(err_count);
    end

    assign load   = (state == SEQ_IDLE) && start;
    assign at_end = (idx == n_used);
    assign rd_req = (state == SEQ_SCAN) && !at_end && in_range;
    assign wr_req = (state == SEQ_FLIP);

    // Main state machine with slot index, fix counter and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= SEQ_IDLE;
            idx           <= '0;
            n_used        <= '0;
            fixed         <= '0;
            unc_pend      <= 1'b0;
            done          <= 1'b0;
            fix_count     <= '0;
            uncorrectable <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        n_used   <= n_next;
                        unc_pend <= (err_count == FULL_CODE);
                        idx      <= '0;
                        fixed    <= '0;
                        state    <= SEQ_SCAN;
                    end
                end
                SEQ_SCAN: begin
                    if (at_end) begin
                        done          <= 1'b1;
                        fix_count     <= fixed;
                        uncorrectable <= unc_pend;
                        state         <= SEQ_IDLE;
                    end else if (in_range) begin
                        state <= SEQ_FLIP;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SEQ_FLIP: begin
                    fixed <= fixed + 1'b1;
                    idx   <= idx + 1'b1;
                    state <= SEQ_SCAN;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sbf_byte_flip.sv
// Buffer port driver: presents the byte address for both halves of the
// read-modify-write and forms the write byte with one bit inverted.
// Assumes read data arrives the cycle after the read request and the
// address is unchanged between the two halves.
module sbf_byte_flip #(
    parameter int ADDR_W = 9
) (
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [2:0]        bit_pos,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wdata
);
    import sbf_pkg::*;

    // Drive the port and build the corrected byte.
    always_comb begin
        buf_addr  = byte_addr;
        buf_rd_en = rd_req;
        buf_wr_en = wr_req;
        buf_wdata = rdata ^ bit_select(bit_pos);
    end

endmodule

// File: rtl/sector_bitfix.sv
// Top level of the sector bit-error corrector. Wires the position unpacker,
// the sequencer and the buffer port driver.
// Assumes a single-port byte buffer with one-cycle read latency.
module sector_bitfix #(
    parameter int LOC_W        = 13,
    parameter int MAX_LOCS     = 8,
    parameter int SECTOR_BYTES = 512,
    parameter int CNT_W        = 4,
    localparam int PACK_W      = LOC_W * MAX_LOCS,
    localparam int IDX_W       = $clog2(MAX_LOCS + 1),
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PACK_W-1:0] err_locs,
    input  logic [CNT_W-1:0]  err_count,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd_en,
    output logic              buf_wr_en,
    output logic [7:0]        buf_wdata,
    input  logic [7:0]        buf_rdata,
    output logic              done,
    output logic [IDX_W-1:0]  fix_count,
    output logic              uncorrectable
);

    logic              load;
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic              rd_req;
    logic              wr_req;
    logic [ADDR_W-1:0] byte_addr;
    logic [2:0]        bit_pos;

    sbf_loc_unpack #(
        .LOC_W(LOC_W), .MAX_LOCS(MAX_LOCS), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_unpack (
        .clk(clk), .rst_n(rst_n), .load(load), .locs_in(err_locs),
        .idx(idx), .byte_addr(byte_addr), .bit_pos(bit_pos),
        .in_range(in_range)
    );

    sbf_seq #(
        .CNT_W(CNT_W), .MAX_LOCS(MAX_LOCS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
        .in_range(in_range), .load(load), .idx(idx), .rd_req(rd_req),
        .wr_req(wr_req), .done(done), .fix_count(fix_count),
        .uncorrectable(uncorrectable)
    );

    sbf_byte_flip #(
        .ADDR_W(ADDR_W)
    ) u_flip (
        .rd_req(rd_req), .wr_req(wr_req), .byte_addr(byte_addr),
        .bit_pos(bit_pos), .rdata(buf_rdata), .buf_addr(buf_addr),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata)
    );

endmodule

// File: rtl/sector_bitfix_chk.sv
// Port-level protocol checks for the sector bit-error corrector.
// Attached to every instance of the top module by the bind below.
module sector_bitfix_chk #(
    parameter int MAX_LOCS = 8,
    parameter int ADDR_W   = 9,
    parameter int IDX_W    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] buf_addr,
    input logic              buf_rd_en,
    input logic              buf_wr_en,
    input logic [7:0]        buf_wdata,
    input logic [7:0]        buf_rdata,
    input logic              done,
    input logic [IDX_W-1:0]  fix_count,
    input logic              uncorrectable
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> buf_wr_en);

    // R4
    write_same_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($past(buf_rd_en) && buf_addr == $past(buf_addr)));

    // R4
    single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1));

    // R4
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));

    // R6
    unc_no_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (fix_count == '0));

    // R5
    fix_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fix_count <= IDX_W'(MAX_LOCS)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(fix_count) || done));

endmodule

bind sector_bitfix sector_bitfix_chk #(
    .MAX_LOCS(MAX_LOCS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
    .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .done(done), .fix_count(fix_count), .uncorrectable(uncorrectable)
);

// File: tb/sector_bitfix_bench.sv
// Bench: behavioural model of the access schedule, results and sector image,
// compared against the design on every clock.
module sector_bitfix_bench;

    localparam int LOC_W   = 13;
    localparam int NLOC    = 8;
    localparam int NBYTES  = 512;
    localparam int CNT_W   = 4;
    localparam int PACK_W  = LOC_W * NLOC;
    localparam int ADDR_W  = 9;
    localparam int IDX_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PACK_W-1:0] err_locs = '0;
    logic [CNT_W-1:0]  err_count = '0;
    logic [ADDR_W-1:0] buf_addr;
    logic              buf_rd_en, buf_wr_en;
    logic [7:0]        buf_wdata, buf_rdata;
    logic              done;
    logic [IDX_W-1:0]  fix_count;
    logic              uncorrectable;

    always #4 clk = ~clk;

    sector_bitfix u_sector_bitfix (
        .clk(clk), .rst_n(rst_n), .start(start), .err_locs(err_locs),
        .err_count(err_count), .buf_addr(buf_addr), .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .done(done), .fix_count(fix_count), .uncorrectable(uncorrectable)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i * 37 + 11);
    endfunction

    // Sector buffer with one-cycle read latency.
    logic [7:0] mem [NBYTES];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= pat(i);
            buf_rdata <= '0;
        end else begin
            if (buf_wr_en) mem[buf_addr] <= buf_wdata;
            if (buf_rd_en) buf_rdata <= mem[buf_addr];
        end
    end

    // Model state.
    logic [7:0] ref_mem [NBYTES];
    int  exp_q[$];
    int  pend_fix, hold_fix;
    bit  pend_unc, hold_unc;
    int  checks = 0, errors = 0;
    logic [PACK_W-1:0] w;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_loc(int k, int adj);
        w[k*LOC_W +: LOC_W] = LOC_W'(adj ^ 3);
    endtask

    // Model: accept a pass and predict schedule, image and results.
    task automatic accept(logic [PACK_W-1:0] locs, int cnt);
        int n;
        n = (cnt == 15) ? 0 : ((cnt > NLOC) ? NLOC : cnt);
        pend_unc = (cnt == 15);
        pend_fix = 0;
        for (int k = 0; k < n; k++) begin
            int adj;
            adj = int'(locs[k*LOC_W +: LOC_W]) ^ 3;
            if (adj < NBYTES * 8) begin
                ref_mem[adj >> 3] = ref_mem[adj >> 3] ^ (8'd1 << (adj & 7));
                exp_q.push_back(1);
                exp_q.push_back(2);
                pend_fix++;
            end else begin
                exp_q.push_back(0);
            end
        end
        exp_q.push_back(0);
        exp_q.push_back(3);
    endtask

    // One cycle: compare at the falling edge, then drive inputs.
    task automatic tick(bit st, logic [PACK_W-1:0] locs, int cnt);
        int code;
        int bad;
        @(negedge clk);
        code = (exp_q.size() > 0) ? exp_q.pop_front() : 0;
        // R7 R8: per-cycle access schedule and done pulse
        chk({buf_rd_en, buf_wr_en, done} == {code == 1, code == 2, code == 3},
            "R8", "rd/wr/done", int'({buf_rd_en, buf_wr_en, done}),
            int'({code == 1, code == 2, code == 3}));
        if (code == 3) begin
            hold_fix = pend_fix;
            hold_unc = pend_unc;
            bad = 0;
            for (int i = 0; i < NBYTES; i++) if (mem[i] !== ref_mem[i]) bad++;
            // R2 R3 R4: sector image after the pass
            chk(bad == 0, "R4", "mismatched bytes", bad, 0);
        end
        // R9 R6: held results
        chk(int'(fix_count) == hold_fix, "R9", "fix_count", int'(fix_count), hold_fix);
        chk(uncorrectable == hold_unc, "R6", "uncorrectable", int'(uncorrectable), int'(hold_unc));
        start     = st;
        err_locs  = locs;
        err_count = CNT_W'(cnt);
        // R10: start taken only when the model is idle
        if (st && exp_q.size() == 0) accept(locs, cnt);
    endtask

    task automatic run(logic [PACK_W-1:0] locs, int cnt);
        tick(1'b1, locs, cnt);
        do tick(1'b0, locs, 0); while (exp_q.size() > 0);
        tick(1'b0, locs, 0);
    endtask

    initial begin
        for (int i = 0; i < NBYTES; i++) ref_mem[i] = pat(i);
        hold_fix = 0; hold_unc = 0; pend_fix = 0; pend_unc = 0;
        w = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(!done && !uncorrectable && fix_count == 0, "R1", "reset outputs",
            int'({done, uncorrectable, fix_count}), 0);
        chk(!buf_rd_en && !buf_wr_en, "R1", "idle port", int'({buf_rd_en, buf_wr_en}), 0);
        repeat (3) tick(1'b0, w, 0);

        // R2 R3 R4: single position at bit 0
        set_loc(0, 0);
        run(w, 1);
        // R4: top bit, middle, bit 7 of byte 0
        set_loc(0, 4095); set_loc(1, 1234); set_loc(2, 7);
        run(w, 3);
        // R7: out-of-range entries interleaved
        set_loc(0, 100); set_loc(1, 4096); set_loc(2, 8191); set_loc(3, 3000);
        run(w, 4);
        // R5: count 0
        run(w, 0);
        // R6: count 15 leaves buffer untouched
        for (int k = 0; k < NLOC; k++) set_loc(k, 64 * k + 9);
        run(w, 15);
        // R5: count 12 clamped to 8
        for (int k = 0; k < NLOC; k++) set_loc(k, 500 * k + 3);
        run(w, 12);
        // R4: same bit twice restores it
        set_loc(0, 555); set_loc(1, 555);
        run(w, 2);
        // R5: only first five of eight valid slots
        for (int k = 0; k < NLOC; k++) set_loc(k, 17 * k + 2000);
        run(w, 5);
        // R10: start pulses while busy are ignored
        set_loc(0, 40); set_loc(1, 41); set_loc(2, 4200);
        tick(1'b1, w, 3);
        for (int j = 0; j < 6; j++) begin
            logic [PACK_W-1:0] other;
            other = ~w;
            tick(1'b1, other, 8);
        end
        do tick(1'b0, w, 0); while (exp_q.size() > 0);
        repeat (3) tick(1'b0, w, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule